// File: doc/BRIEF.md
# System Configuration Register Block

This block holds the chip-level configuration state that a CPU programs over a simple APB-style register bus. It selects which memory answers at address zero during boot, moves five DMA requests onto alternate channels, turns on the strong drive for four I2C-capable pins, and routes one of five GPIO ports onto each of sixteen external-interrupt lines. A guard register holds set-only routing bits that gate three fault sources onto a timer break output. The same register also holds a sticky SRAM parity error flag, which software clears by writing a one to it.

Two reset inputs reach the block. The system reset clears everything and loads the boot selector from non-volatile option inputs. The peripheral (bus) reset clears only the DMA, drive and interrupt-routing state. Both resets assert asynchronously and are released through two-stage synchronizers, so a register access must wait at least three clock edges after either reset is released. A write takes effect on the clock edge that ends the access phase. Reads are combinational while `psel` is high and `pwrite` is low.

Word map (`paddr[4:2]`): 0 control, 1 to 4 line-select registers, 5 guard, 6 and 7 unmapped.

Top module: `sys_cfg_regs`

## Requirements
- R1: The control bits [1:0] hold the boot selector. Code 01 asserts `map_sysmem_o`, code 11 asserts `map_sram_o`, and codes 00 and 10 assert `map_flash_o`. A system reset loads the selector from `boot_opt_i`. A control write replaces it.
- R2: A bus reset leaves the boot selector, the lock bits and the parity flag unchanged. It clears the DMA remap bits, the drive enables and all line selects.
- R3: Line n has a 4-bit code in word 1+n/4, bits 4*(n%4)+3 down to 4*(n%4). Bits 31:16 of those words are not stored.
- R4: Codes 0 to 4 select ports A, B, C, D and F, in that order, which are `pins_i[k*16+15:k*16]` for code k. `line_o[n]` equals bit n of the selected port. Any other code drives the line to 0.
- R5: Guard bits [0], [1] and [2] route, in that order, `lvd_i`, `sram_perr_i` and `lockup_i`. Writing a 1 sets a bit. Writing a 0 has no effect. Only a system reset clears these bits.
- R6: The guard bit [8] is set by `sram_perr_i` and cleared by writing a 1 to it. Writing a 0 leaves it unchanged. A parity error in the same cycle as a clearing write leaves it set.
- R7: Control bits [8:4] are remap bits for requests 0 to 4. Each request's 3-bit field in `dma_chan_o` carries its channel. The default and alternate channels are 1/2, 3/4, 3/5, 2/4 and 1/2.
- R8: Control bits [19:16] drive `fmp_o[3:0]` directly.
- R9: `brk_o` is the OR, over the three guard bits, of each set bit ANDed with its live fault input.
- R10: Unimplemented bits of mapped words read as zero. Words 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low |
| bus_rst_n | input | 1 | Peripheral bus reset, active low |
| boot_opt_i | input | 2 | Option value for the boot selector |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| boot_sel_o | output | 2 | Raw boot selector |
| map_flash_o | output | 1 | Main flash at address zero |
| map_sysmem_o | output | 1 | Boot memory at address zero |
| map_sram_o | output | 1 | SRAM at address zero |
| dma_chan_o | output | 15 | Channel per DMA request, 3 bits each |
| fmp_o | output | 4 | Strong-drive enables |
| pins_i | input | 80 | Five GPIO ports, 16 bits each |
| line_o | output | 16 | Interrupt lines |
| lvd_i | input | 1 | Low-voltage detect event |
| sram_perr_i | input | 1 | Live SRAM parity error |
| lockup_i | input | 1 | CPU lockup |
| brk_o | output | 1 | Timer break request |

## Verification
The assertions assume that `boot_opt_i` does not change while the system reset is released. They also assume that the bus reset is never asserted without the system reset while a write to the guard word is in progress. The stimulus changes the option inputs only while the system reset is held, and issues resets only between bus transfers. Parity pulses in the random phase are raised and dropped between two clock edges, so they reach `brk_o` but never the flag. The flag is driven only by directed pulses, one of which coincides with a clearing write.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
  localparam int unsigned NDMA      = 5;
  localparam int unsigned NFMP      = 4;
  localparam int unsigned NBRK      = 3;
  localparam int unsigned CH_W      = 3;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned BOOT_LSB  = 0;
  localparam int unsigned DMA_LSB   = 4;
  localparam int unsigned FMP_LSB   = 16;
  localparam int unsigned FLAG_BIT  = 8;

  // channel used by a DMA request when its remap bit is clear
  function automatic logic [CH_W-1:0] home_chan(input int unsigned req);
    case (req)
      0: return 3'd1;
      1: return 3'd3;
      2: return 3'd3;
      3: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // channel used when the remap bit is set
  function automatic logic [CH_W-1:0] moved_chan(input int unsigned req);
    case (req)
      0: return 3'd2;
      1: return 3'd4;
      2: return 3'd5;
      3: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/sys_cfg_rst_sync.sv
module sys_cfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/sys_cfg_guard.sv
module sys_cfg_guard
  import sys_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            srst_n,
  input  logic            wr_i,
  input  logic [NBRK-1:0] set_i,
  input  logic            clr_i,
  input  logic            lvd_i,
  input  logic            perr_i,
  input  logic            lockup_i,
  output logic [NBRK-1:0] lock_o,
  output logic            flag_o,
  output logic            brk_o
);
  logic [NBRK-1:0] lock_q, lock_d;
  logic            flag_q, flag_d;
  logic [NBRK-1:0] fault;

  always_comb begin
    lock_d = lock_q;
    if (wr_i) lock_d = lock_q | set_i;
    flag_d = perr_i | (flag_q & ~(wr_i & clr_i));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   lock_q <= '0;
    else if (wr_i) lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign fault  = {lockup_i, perr_i, lvd_i};
  assign brk_o  = |(lock_q & fault);
  assign lock_o = lock_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sys_cfg_line_mux.sv
module sys_cfg_line_mux
  import sys_cfg_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  parameter int unsigned NPORTS = 5
) (
  input  logic [NLINES*CODE_W-1:0] sel_i,
  input  logic [NPORTS*NLINES-1:0] pins_i,
  output logic [NLINES-1:0]        line_o
);
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    logic [CODE_W-1:0] code;
    logic [NPORTS-1:0] col;
    assign code = sel_i[n*CODE_W +: CODE_W];
    for (genvar p = 0; p < NPORTS; p++) begin : g_col
      assign col[p] = pins_i[p*NLINES + n];
    end
    always_comb begin
      line_o[n] = 1'b0;
      for (int p = 0; p < NPORTS; p++)
        if (code == CODE_W'(p)) line_o[n] = col[p];
    end
  end
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
  import sys_cfg_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  parameter int unsigned NPORTS = 5,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     sys_rst_n,
  input  logic                     bus_rst_n,
  input  logic [1:0]               boot_opt_i,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [31:0]              pwdata,
  output logic [31:0]              prdata,
  output logic [1:0]               boot_sel_o,
  output logic                     map_flash_o,
  output logic                     map_sysmem_o,
  output logic                     map_sram_o,
  output logic [NDMA*CH_W-1:0]     dma_chan_o,
  output logic [NFMP-1:0]          fmp_o,
  input  logic [NPORTS*NLINES-1:0] pins_i,
  output logic [NLINES-1:0]        line_o,
  input  logic                     lvd_i,
  input  logic                     sram_perr_i,
  input  logic                     lockup_i,
  output logic                     brk_o
);
  localparam int unsigned LPR       = 4;
  localparam int unsigned NSEL      = NLINES / LPR;
  localparam int unsigned SEL_W     = LPR * CODE_W;
  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned IDX_GUARD = NSEL + 1;

  logic                     srst_n, prst_n, per_arst_n;
  logic                     wr_en, wr_ctrl, wr_guard;
  logic [IDX_W-1:0]         rd_idx;
  logic [1:0]               boot_q, boot_d;
  logic [NDMA-1:0]          dma_q, dma_d;
  logic [NFMP-1:0]          fmp_q, fmp_d;
  logic [NLINES*CODE_W-1:0] sel_q, sel_d;
  logic [NSEL-1:0]          sel_we;
  logic [NBRK-1:0]          lock_q;
  logic                     flag_q;

  assign per_arst_n = sys_rst_n & bus_rst_n;

  sys_cfg_rst_sync u_sync_sys (.clk(clk), .arst_n(sys_rst_n),  .rst_n_o(srst_n));
  sys_cfg_rst_sync u_sync_per (.clk(clk), .arst_n(per_arst_n), .rst_n_o(prst_n));

  assign wr_en    = psel & penable & pwrite;
  assign rd_idx   = paddr[ADDR_W-1:2];
  assign wr_ctrl  = wr_en && (rd_idx == IDX_W'(0));
  assign wr_guard = wr_en && (rd_idx == IDX_W'(IDX_GUARD));

  for (genvar k = 0; k < NSEL; k++) begin : g_we
    assign sel_we[k] = wr_en && (rd_idx == IDX_W'(k + 1));
  end

  always_comb begin
    boot_d = boot_q;
    dma_d  = dma_q;
    fmp_d  = fmp_q;
    sel_d  = sel_q;
    if (wr_ctrl) begin
      boot_d = pwdata[BOOT_LSB +: 2];
      dma_d  = pwdata[DMA_LSB +: NDMA];
      fmp_d  = pwdata[FMP_LSB +: NFMP];
    end
    for (int k = 0; k < NSEL; k++)
      if (sel_we[k]) sel_d[k*SEL_W +: SEL_W] = pwdata[SEL_W-1:0];
  end

  // boot selector lives in the system domain and reloads from the options
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      boot_q <= boot_opt_i;
    else if (wr_ctrl) boot_q <= boot_d;
  end

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n) begin
      dma_q <= '0;
      fmp_q <= '0;
    end else if (wr_ctrl) begin
      dma_q <= dma_d;
      fmp_q <= fmp_d;
    end
  end

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n)      sel_q <= '0;
    else if (|sel_we) sel_q <= sel_d;
  end

  sys_cfg_guard u_guard (
    .clk(clk), .srst_n(srst_n), .wr_i(wr_guard),
    .set_i(pwdata[NBRK-1:0]), .clr_i(pwdata[FLAG_BIT]),
    .lvd_i(lvd_i), .perr_i(sram_perr_i), .lockup_i(lockup_i),
    .lock_o(lock_q), .flag_o(flag_q), .brk_o(brk_o)
  );

  sys_cfg_line_mux #(.NLINES(NLINES), .NPORTS(NPORTS)) u_mux (
    .sel_i(sel_q), .pins_i(pins_i), .line_o(line_o)
  );

  assign boot_sel_o   = boot_q;
  assign map_sysmem_o = (boot_q == 2'b01);
  assign map_sram_o   = (boot_q == 2'b11);
  assign map_flash_o  = ~boot_q[0];
  assign fmp_o        = fmp_q;

  for (genvar r = 0; r < NDMA; r++) begin : g_dma
    assign dma_chan_o[r*CH_W +: CH_W] = dma_q[r] ? moved_chan(r) : home_chan(r);
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (rd_idx == IDX_W'(0)) begin
        prdata[BOOT_LSB +: 2]   = boot_q;
        prdata[DMA_LSB +: NDMA] = dma_q;
        prdata[FMP_LSB +: NFMP] = fmp_q;
      end
      for (int k = 0; k < NSEL; k++)
        if (rd_idx == IDX_W'(k + 1)) prdata[SEL_W-1:0] = sel_q[k*SEL_W +: SEL_W];
      if (rd_idx == IDX_W'(IDX_GUARD)) begin
        prdata[NBRK-1:0] = lock_q;
        prdata[FLAG_BIT] = flag_q;
      end
    end
  end
endmodule

// File: rtl/sys_cfg_chk.sv
module sys_cfg_chk #(
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned IDX_GUARD = 5
) (
  input logic             clk,
  input logic             srst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       boot_q,
  input logic [2:0]       lock_q,
  input logic             flag_q,
  input logic             perr_i,
  input logic             brk_o,
  input logic [4:0]       dma_q,
  input logic [14:0]      dma_chan_o,
  input logic             psel,
  input logic             pwrite,
  input logic [31:0]      prdata
);
  p_boot_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !(wr_en && idx == IDX_W'(0)) |=> $stable(boot_q));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!srst_n)
    perr_i |=> flag_q);

  p_brk_quiet_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (lock_q == 3'b000) |-> !brk_o);

  p_dma_home_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !dma_q[0] |-> (dma_chan_o[2:0] == 3'd1));

  p_dma_moved_r7: assert property (@(posedge clk) disable iff (!srst_n)
    dma_q[0] |-> (dma_chan_o[2:0] == 3'd2));

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (psel && !pwrite && idx == IDX_W'(IDX_GUARD)) |-> (prdata[31:9] == '0 && prdata[7:3] == '0));
endmodule

bind sys_cfg_regs sys_cfg_chk u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .idx(rd_idx),
  .boot_q(boot_q), .lock_q(lock_q), .flag_q(flag_q), .perr_i(sram_perr_i),
  .brk_o(brk_o), .dma_q(dma_q), .dma_chan_o(dma_chan_o),
  .psel(psel), .pwrite(pwrite), .prdata(prdata)
);

// File: tb/test_sys_cfg_regs.sv
module test_sys_cfg_regs;
  logic        clk = 1'b0;
  logic        sys_rst_n = 1'b0, bus_rst_n = 1'b0;
  logic [1:0]  boot_opt_i = 2'b11;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  boot_sel_o;
  logic        map_flash_o, map_sysmem_o, map_sram_o;
  logic [14:0] dma_chan_o;
  logic [3:0]  fmp_o;
  logic [79:0] pins_i = '0;
  logic [15:0] line_o;
  logic        lvd_i = 0, sram_perr_i = 0, lockup_i = 0;
  logic        brk_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0]  m_boot;
  logic [4:0]  m_dma;
  logic [3:0]  m_fmp;
  logic [63:0] m_sel;
  logic [2:0]  m_lock;
  logic        m_flag;

  always #5 clk = ~clk;

  sys_cfg_regs i_sys_cfg_regs (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_chan(input int r, input logic moved);
    logic [2:0] h [5] = '{3'd1, 3'd3, 3'd3, 3'd2, 3'd1};
    logic [2:0] a [5] = '{3'd2, 3'd4, 3'd5, 3'd4, 3'd2};
    return moved ? a[r] : h[r];
  endfunction

  function automatic logic exp_line(input int n);
    logic [3:0] c = m_sel[n*4 +: 4];
    return (c < 4'd5) ? pins_i[c*16 + n] : 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(input int idx);
    logic [31:0] d = '0;
    if (idx == 0) begin d[1:0] = m_boot; d[8:4] = m_dma; d[19:16] = m_fmp; end
    else if (idx >= 1 && idx <= 4) d[15:0] = m_sel[(idx-1)*16 +: 16];
    else if (idx == 5) begin d[2:0] = m_lock; d[8] = m_flag; end
    return d;
  endfunction

  task automatic apb_write(input int idx, input logic [31:0] d, input logic perr);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 5'(idx << 2); pwdata = d;
    @(negedge clk); penable = 1; sram_perr_i = perr;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; sram_perr_i = 0;
    if (idx == 0) begin m_boot = d[1:0]; m_dma = d[8:4]; m_fmp = d[19:16]; end
    else if (idx >= 1 && idx <= 4) m_sel[(idx-1)*16 +: 16] = d[15:0];
    else if (idx == 5) m_lock = m_lock | d[2:0];
    m_flag = perr | (m_flag & ~(idx == 5 && d[8]));
  endtask

  task automatic apb_read_check(input int idx, input string tag);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 5'(idx << 2);
    @(negedge clk); penable = 1; #1;
    check(tag, prdata, exp_read(idx));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // called just after a falling edge; all stimulus is withdrawn before the next rise
  task automatic check_outputs();
    pins_i = {$urandom(), $urandom(), $urandom()} >> 16;
    lvd_i = 1'($urandom()); lockup_i = 1'($urandom()); sram_perr_i = 1'($urandom());
    #1;
    check("R1 boot_sel", 32'(boot_sel_o), 32'(m_boot));
    check("R1 map", {29'd0, map_flash_o, map_sysmem_o, map_sram_o},
          {29'd0, !m_boot[0], m_boot == 2'b01, m_boot == 2'b11});
    for (int r = 0; r < 5; r++)
      check("R7 dma_chan", 32'(dma_chan_o[r*3 +: 3]), 32'(exp_chan(r, m_dma[r])));
    check("R8 fmp", 32'(fmp_o), 32'(m_fmp));
    for (int n = 0; n < 16; n++)
      check("R4 line", 32'(line_o[n]), 32'(exp_line(n)));
    check("R9 brk", 32'(brk_o), 32'(|(m_lock & {lockup_i, sram_perr_i, lvd_i})));
    #1; sram_perr_i = 0; lvd_i = 0; lockup_i = 0;
  endtask

  task automatic do_sys_reset(input logic [1:0] opt);
    @(negedge clk); sys_rst_n = 0; boot_opt_i = opt;
    repeat (3) @(negedge clk);
    sys_rst_n = 1;
    repeat (4) @(negedge clk);
    m_boot = opt; m_dma = '0; m_fmp = '0; m_sel = '0; m_lock = '0; m_flag = 0;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    bus_rst_n = 1;
    do_sys_reset(2'b11);
    check_outputs();                                // R1 reset loads SRAM selection
    apb_read_check(5, "R5 guard reset");
    apb_read_check(0, "R1 ctrl reset");

    apb_write(0, 32'h0000_0002, 0);                 // code 10 maps flash
    check_outputs();

    // R3 R4: each port code and an out-of-range code on line 5
    for (int c = 0; c < 7; c++) begin
      apb_write(2, 32'(c) << 4, 0);
      check_outputs();
      apb_read_check(2, "R3 sel word");
    end

    // random mix of writes, including unmapped words (R10)
    for (int it = 0; it < 300; it++) begin
      int idx = int'($urandom_range(0, 7));
      logic [31:0] d = $urandom();
      if (idx == 5) d[8] = 0;
      apb_write(idx, d, 0);
      check_outputs();
      apb_read_check(int'($urandom_range(0, 7)), "R10 readback");
    end

    // R5 writing zero to the guard changes nothing
    apb_write(5, 32'h0000_0005, 0);
    apb_write(5, 32'h0000_0000, 0);
    apb_read_check(5, "R5 zero write");
    check_outputs();

    // R6 flag set, zero write, coincident clear, real clear
    @(negedge clk); sram_perr_i = 1; @(negedge clk); sram_perr_i = 0; m_flag = 1;
    apb_read_check(5, "R6 flag set");
    apb_write(5, 32'h0, 0);
    apb_read_check(5, "R6 zero write");
    apb_write(5, 32'h100, 1);
    apb_read_check(5, "R6 set wins");
    apb_write(5, 32'h100, 0);
    apb_read_check(5, "R6 cleared");

    // R2 bus reset
    apb_write(0, 32'h000F_01F1, 0);
    apb_write(3, 32'h0000_4321, 0);
    @(negedge clk); sram_perr_i = 1; @(negedge clk); sram_perr_i = 0; m_flag = 1;
    @(negedge clk); bus_rst_n = 0;
    repeat (3) @(negedge clk);
    bus_rst_n = 1;
    repeat (4) @(negedge clk);
    m_dma = '0; m_fmp = '0; m_sel = '0;
    check_outputs();
    apb_read_check(0, "R2 ctrl after bus reset");
    apb_read_check(3, "R2 sel after bus reset");
    apb_read_check(5, "R2 guard after bus reset");

    // R5 system reset clears locks and reloads the selector
    do_sys_reset(2'b01);
    check_outputs();
    apb_read_check(5, "R5 sys reset");
    apb_read_check(0, "R1 reload");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule